// File: doc/BRIEF.md
# Programmable Interval Timer with Interrupt

This block is a 16-bit interval timer controlled through a small register window. Software writes the terminal count N as a low byte and a high byte. It picks one of two modes and issues commands through a command register. In one-shot mode the timer output drops low for N clocks after a start and then returns high. At that moment it flags an interrupt and halts. In repeating mode the output is a square wave: high for P = floor(N/2) clocks, then low for Q = N - P clocks, again and again. Every return to high flags an interrupt, which is once per N clocks.

A small state machine drives the timer. It has three states. `ST_IDLE` is stopped, with the output high. `ST_HIGH` is the high phase of the repeating mode. `ST_LOW` is the low phase, used by both modes. The transitions are:

| Transition | Path |
|---|---|
| start-repeat | `ST_IDLE` to `ST_HIGH` |
| start-single | `ST_IDLE` to `ST_LOW` |
| high-expire | `ST_HIGH` to `ST_LOW` |
| low-expire-repeat | `ST_LOW` to `ST_HIGH`, flags the interrupt |
| low-expire-single | `ST_LOW` to `ST_IDLE`, flags the interrupt |
| halt | any state to `ST_IDLE`, on a stop or reset command |

While the timer runs, count writes and mode changes are locked out. A second start is also ignored. A pending interrupt stays pending through stop and restart. It clears only when the control register is read or when a reset command is issued. The timer level can also be steered onto general-purpose pin 0. While it is steered there, it takes that pin over as an output.

Top module: `interval_timer`

## Requirements
- R1: After `rst_n` is released, `tmr_out` is 1 and `irq` is 0. Every register reads 0x00. Pin 0 passes `gp_level` and `gp_oe` straight through.
- R2: A write of 0x02 to address 3 stops the timer. This is the stop command. `tmr_out` is 1 from the next cycle, and the timer stays idle.
- R3: A write of 0x03 to address 3 is the reset command. On the next cycle the timer is idle, and the pending flag, both count bytes and all control bits are 0.
- R4: The repeating mode is set by control bit 1 = 1 at address 2. A write of 0x01 to address 3 is the start command. After a start in this mode, `tmr_out` is 1 for P = floor(N/2) cycles and then 0 for Q = N - P cycles, and this repeats. N is {address 1, address 0}. N values of 0 and 1 act as 2.
- R5: In repeating mode, the pending flag is set on every cycle in which `tmr_out` returns to 1 from a timeout. That is once every N cycles.
- R6: One-shot mode is control bit 1 = 0. After a start in this mode, `tmr_out` is 0 for N cycles and then 1. At that same point the timer goes idle and the pending flag is set.
- R7: While the timer runs, several writes have no effect. Writes to address 0 and address 1 are ignored. Control bit 1 (the mode) is not changed by a write. A further start command is ignored.
- R8: Address 2 reads 0x01 when control bit 0 (interrupt enable) and the pending flag are both 1. In every other case it reads 0x00. A read of address 2 with `rd_en` clears the pending flag from the next cycle. If a timeout sets the flag in that same cycle, the flag stays set.
- R9: The pending flag survives a stop command and a later restart. It is set even while the enable bit is 0. `irq` is the pending flag ANDed with the enable bit.
- R10: When control bit 2 is 1, `pin0_oe` is 1 and `pin0_out` follows `tmr_out`. When control bit 2 is 0, the pin takes `gp_oe` and `gp_level`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register address: 0 count low, 1 count high, 2 control, 3 command |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| gp_level | input | 1 | Level that the general-purpose logic wants on pin 0 |
| gp_oe | input | 1 | Output enable that the general-purpose logic wants on pin 0 |
| tmr_out | output | 1 | Timer output level |
| irq | output | 1 | Interrupt request |
| pin0_out | output | 1 | Level driven to pin 0 |
| pin0_oe | output | 1 | Output enable for pin 0 |

## Verification
On every cycle the assertions check the following. After a stop, the output is high and the timer is idle. A reset command clears the interrupt. Any return of the output to high that no command forced comes with a pending flag. A running timer keeps its count bytes. A control read clears the flag unless a timeout lands in the same cycle. A steered pin follows the timer. Only the bench's scenarios can show the exact P and Q phase lengths for even, odd and degenerate N, as well as the one-shot duration, the full count width through the high byte, the survival of the flag across stop and restart, and a collision of set and clear under a continuous read. The bench checks these against a behavioural model on every clock.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HIGH = 2'd1,
        ST_LOW  = 2'd2
    } tmr_state_e;

    localparam logic [1:0] ADR_CNT_LO = 2'd0;
    localparam logic [1:0] ADR_CNT_HI = 2'd1;
    localparam logic [1:0] ADR_CTRL   = 2'd2;
    localparam logic [1:0] ADR_CMD    = 2'd3;

    localparam logic [7:0] CMD_START  = 8'h01;
    localparam logic [7:0] CMD_STOP   = 8'h02;
    localparam logic [7:0] CMD_RESET  = 8'h03;

    localparam int CTL_IRQ_EN = 0;
    localparam int CTL_REPEAT = 1;
    localparam int CTL_ROUTE  = 2;
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [1:0]       addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic             running,
    input  logic             pend_set,
    output logic [DATA_W-1:0] rdata,
    output logic [CNT_W-1:0] count,
    output logic             irq_en,
    output logic             mode_rep,
    output logic             route,
    output logic             pending,
    output logic             cmd_start,
    output logic             cmd_halt,
    output logic             cmd_reset
);
    localparam int HI_W = CNT_W - DATA_W;

    logic [DATA_W-1:0] cnt_lo;
    logic [HI_W-1:0]   cnt_hi;
    logic              cmd_wr;
    logic              ctl_rd;

    assign cmd_wr    = wr_en && (addr == ADR_CMD);
    assign cmd_start = cmd_wr && (wdata == CMD_START);
    assign cmd_reset = cmd_wr && (wdata == CMD_RESET);
    assign cmd_halt  = cmd_wr && ((wdata == CMD_STOP) || (wdata == CMD_RESET));
    assign ctl_rd    = rd_en && (addr == ADR_CTRL);
    assign count     = {cnt_hi, cnt_lo};

    always_ff @(posedge clk) begin
        if (!rst_n || cmd_reset) begin
            cnt_lo   <= '0;
            cnt_hi   <= '0;
            irq_en   <= 1'b0;
            mode_rep <= 1'b0;
            route    <= 1'b0;
            pending  <= 1'b0;
        end else begin
            if (wr_en && !running && addr == ADR_CNT_LO) cnt_lo <= wdata;
            if (wr_en && !running && addr == ADR_CNT_HI) cnt_hi <= wdata[HI_W-1:0];
            if (wr_en && addr == ADR_CTRL) begin
                irq_en <= wdata[CTL_IRQ_EN];
                route  <= wdata[CTL_ROUTE];
                if (!running) mode_rep <= wdata[CTL_REPEAT];
            end
            if (pend_set)    pending <= 1'b1;
            else if (ctl_rd) pending <= 1'b0;
        end
    end

    always_comb begin
        unique case (addr)
            ADR_CNT_LO: rdata = cnt_lo;
            ADR_CNT_HI: rdata = DATA_W'(cnt_hi);
            ADR_CTRL:   rdata = DATA_W'(irq_en && pending);
            default:    rdata = '0;
        endcase
    end
endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_start,
    input  logic             cmd_halt,
    input  logic             mode_rep,
    input  logic [CNT_W-1:0] count,
    output logic             tmr_out,
    output logic             running,
    output logic             pend_set
);
    localparam logic [CNT_W-1:0] MIN_N = CNT_W'(2);

    tmr_state_e       state, state_nxt;
    logic [CNT_W-1:0] cnt, cnt_nxt;
    logic [CNT_W-1:0] n_eff, hi_len, lo_len;
    logic             expire;

    assign n_eff  = (count < MIN_N) ? MIN_N : count;
    assign hi_len = n_eff >> 1;
    assign lo_len = n_eff - hi_len;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        cnt_nxt   = cnt;
        expire    = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (cmd_start) begin
                    if (mode_rep) begin
                        state_nxt = ST_HIGH;
                        cnt_nxt   = hi_len - 1'b1;
                    end else begin
                        state_nxt = ST_LOW;
                        cnt_nxt   = n_eff - 1'b1;
                    end
                end
            end
            ST_HIGH: begin
                if (cnt == '0) begin
                    state_nxt = ST_LOW;
                    cnt_nxt   = lo_len - 1'b1;
                end else begin
                    cnt_nxt = cnt - 1'b1;
                end
            end
            ST_LOW: begin
                if (cnt == '0) begin
                    expire = 1'b1;
                    if (mode_rep) begin
                        state_nxt = ST_HIGH;
                        cnt_nxt   = hi_len - 1'b1;
                    end else begin
                        state_nxt = ST_IDLE;
                    end
                end else begin
                    cnt_nxt = cnt - 1'b1;
                end
            end
            default: state_nxt = ST_IDLE;
        endcase
        if (cmd_halt) begin
            state_nxt = ST_IDLE;
            expire    = 1'b0;
        end
    end

    always_comb begin
        tmr_out  = (state != ST_LOW);
        running  = (state != ST_IDLE);
        pend_set = expire;
    end
endmodule

// File: rtl/tmr_pinmux.sv
module tmr_pinmux (
    input  logic route,
    input  logic tmr_out,
    input  logic gp_level,
    input  logic gp_oe,
    output logic pin_out,
    output logic pin_oe
);
    always_comb begin
        pin_out = route ? tmr_out : gp_level;
        pin_oe  = route ? 1'b1    : gp_oe;
    end
endmodule

// File: rtl/interval_timer.sv
module interval_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              gp_level,
    input  logic              gp_oe,
    output logic              tmr_out,
    output logic              irq,
    output logic              pin0_out,
    output logic              pin0_oe
);
    logic [CNT_W-1:0] count;
    logic irq_en, mode_rep, route, pending;
    logic cmd_start, cmd_halt, cmd_reset;
    logic running, pend_set;

    tmr_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) i_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .running(running), .pend_set(pend_set),
        .rdata(rdata), .count(count), .irq_en(irq_en), .mode_rep(mode_rep),
        .route(route), .pending(pending), .cmd_start(cmd_start),
        .cmd_halt(cmd_halt), .cmd_reset(cmd_reset)
    );

    tmr_core #(.CNT_W(CNT_W)) i_core (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_halt(cmd_halt),
        .mode_rep(mode_rep), .count(count), .tmr_out(tmr_out),
        .running(running), .pend_set(pend_set)
    );

    tmr_pinmux i_pin (
        .route(route), .tmr_out(tmr_out), .gp_level(gp_level), .gp_oe(gp_oe),
        .pin_out(pin0_out), .pin_oe(pin0_oe)
    );

    assign irq = pending && irq_en;
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker
    import tmr_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic       rd_en,
    input logic [1:0] addr,
    input logic [7:0] wdata,
    input logic       tmr_out,
    input logic       irq,
    input logic       pin0_out,
    input logic       pin0_oe,
    input logic       running,
    input logic       pend_set,
    input logic       cmd_halt,
    input logic       pending,
    input logic [7:0] cnt_lo,
    input logic       route
);
    a_r2_stop_high: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADR_CMD && wdata == CMD_STOP) |=> (tmr_out && !running));

    a_r3_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADR_CMD && wdata == CMD_RESET) |=> (!pending && !irq && !running));

    a_r5_rise_sets_pending: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(tmr_out) && !$past(cmd_halt)) |-> pending);

    a_r7_count_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (running && wr_en && addr == ADR_CNT_LO) |=> $stable(cnt_lo));

    a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == ADR_CTRL && !pend_set && !(wr_en && addr == ADR_CMD)) |=> !pending);

    a_r10_pin_routed: assert property (@(posedge clk) disable iff (!rst_n)
        route |-> (pin0_oe && pin0_out == tmr_out));
endmodule

bind interval_timer tmr_checker i_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .tmr_out(tmr_out), .irq(irq), .pin0_out(pin0_out),
    .pin0_oe(pin0_oe), .running(running), .pend_set(pend_set),
    .cmd_halt(cmd_halt), .pending(pending), .cnt_lo(count[7:0]), .route(route)
);

// File: tb/test_interval_timer.sv
module test_interval_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       gp_level = 1'b0;
    logic       gp_oe = 1'b0;
    logic       tmr_out, irq, pin0_out, pin0_oe;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    interval_timer i_interval_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .gp_level(gp_level), .gp_oe(gp_oe),
        .tmr_out(tmr_out), .irq(irq), .pin0_out(pin0_out), .pin0_oe(pin0_oe)
    );

    // behavioural reference model: run 0 idle, 1 high phase, 2 low phase
    int m_lo, m_hi, m_en, m_mode, m_route, m_pend, m_run, m_left;

    always @(posedge clk) begin
        int n, p, q, run0, set;
        bit halt, rst_cmd;
        if (!rst_n) begin
            m_lo = 0; m_hi = 0; m_en = 0; m_mode = 0; m_route = 0;
            m_pend = 0; m_run = 0; m_left = 0;
        end else begin
            n = m_hi * 256 + m_lo;
            if (n < 2) n = 2;
            p = n / 2;
            q = n - p;
            run0 = m_run;
            set = 0;
            halt = wr_en && addr == 3 && (wdata == 8'h02 || wdata == 8'h03);
            rst_cmd = wr_en && addr == 3 && wdata == 8'h03;
            if (run0 == 1) begin
                m_left--;
                if (m_left == 0) begin m_run = 2; m_left = q; end
            end else if (run0 == 2) begin
                m_left--;
                if (m_left == 0) begin
                    set = 1;
                    if (m_mode != 0) begin m_run = 1; m_left = p; end
                    else m_run = 0;
                end
            end else if (wr_en && addr == 3 && wdata == 8'h01) begin
                if (m_mode != 0) begin m_run = 1; m_left = p; end
                else begin m_run = 2; m_left = n; end
            end
            if (halt) begin m_run = 0; set = 0; end
            if (set != 0) m_pend = 1;
            else if (rd_en && addr == 2) m_pend = 0;
            if (wr_en && run0 == 0 && addr == 0) m_lo = wdata;
            if (wr_en && run0 == 0 && addr == 1) m_hi = wdata;
            if (wr_en && addr == 2) begin
                m_en = wdata[0];
                m_route = wdata[2];
                if (run0 == 0) m_mode = wdata[1];
            end
            if (rst_cmd) begin
                m_lo = 0; m_hi = 0; m_en = 0; m_mode = 0; m_route = 0; m_pend = 0;
            end
        end
    end

    function automatic int exp_rdata();
        case (addr)
            2'd0: return m_lo;
            2'd1: return m_hi;
            2'd2: return (m_en != 0 && m_pend != 0) ? 1 : 0;
            default: return 0;
        endcase
    endfunction

    // every-cycle comparison, 2 ns after the falling edge
    always begin
        int eo, ei;
        @(negedge clk);
        #2;
        if (rst_n && !done) begin
            eo = (m_run != 2) ? 1 : 0;
            ei = (m_en != 0 && m_pend != 0) ? 1 : 0;
            checks++;
            if (int'(tmr_out) != eo) begin
                errors++;
                $display("FAIL R4 R6 tmr_out actual %0d expected %0d at %0t", tmr_out, eo, $time);
            end
            checks++;
            if (int'(irq) != ei) begin
                errors++;
                $display("FAIL R9 irq actual %0d expected %0d at %0t", irq, ei, $time);
            end
            checks++;
            if (int'(rdata) != exp_rdata()) begin
                errors++;
                $display("FAIL R8 rdata actual %0d expected %0d at %0t", rdata, exp_rdata(), $time);
            end
            checks++;
            if (pin0_oe != (m_route != 0 ? 1'b1 : gp_oe) ||
                pin0_out != (m_route != 0 ? (m_run != 2) : gp_level)) begin
                errors++;
                $display("FAIL R10 pin actual %0d/%0d expected route %0d at %0t",
                         pin0_oe, pin0_out, m_route, $time);
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rdchk(input logic [1:0] a, input int exp, input string tag);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1;
        chk(int'(rdata) == exp, tag, int'(rdata), exp);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run hung, actual no completion, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        #1;
        chk(tmr_out == 1'b1, "R1 tmr_out after reset", tmr_out, 1);
        chk(irq == 1'b0, "R1 irq after reset", irq, 0);
        rdchk(2'd0, 0, "R1 count low after reset");
        rdchk(2'd2, 0, "R1 control after reset");
        gp_level = 1'b1; gp_oe = 1'b1;
        idle(1); #1;
        chk(pin0_oe == 1'b1 && pin0_out == 1'b1, "R10 pin passthrough", pin0_out, 1);

        // R4 R5 repeating mode, odd N = 7: P = 3, Q = 4
        wr(2'd0, 8'd7);
        wr(2'd1, 8'd0);
        wr(2'd2, 8'b011);
        wr(2'd3, 8'h01);
        #1; chk(tmr_out == 1'b1, "R4 high phase start", tmr_out, 1);
        idle(2); #1; chk(tmr_out == 1'b1, "R4 high phase end", tmr_out, 1);
        idle(1); #1; chk(tmr_out == 1'b0, "R4 low phase start", tmr_out, 0);
        idle(3); #1; chk(tmr_out == 1'b0, "R4 low phase end", tmr_out, 0);
        idle(1); #1; chk(tmr_out == 1'b1 && irq == 1'b1, "R5 rise sets pending", irq, 1);

        // R7 lockout while running
        wr(2'd0, 8'd20);
        rdchk(2'd0, 7, "R7 count write ignored while running");
        wr(2'd2, 8'b001);
        wr(2'd3, 8'h01);
        idle(20);

        // R2 stop, R9 pending survives stop and restart
        wr(2'd3, 8'h02);
        #1; chk(tmr_out == 1'b1, "R2 output high after stop", tmr_out, 1);
        idle(3);
        rdchk(2'd2, 1, "R9 pending kept after stop");
        rdchk(2'd2, 0, "R8 read cleared pending");

        // N = 1 acts as 2, mode still repeating; continuous control reads
        wr(2'd0, 8'd1);
        wr(2'd3, 8'h01);
        idle(7);
        wr(2'd3, 8'h02);
        wr(2'd0, 8'd4);
        wr(2'd3, 8'h01);
        @(negedge clk); addr = 2'd2; rd_en = 1'b1;
        idle(14);
        rd_en = 1'b0;
        wr(2'd3, 8'h02);

        // R6 one-shot, enable off, N = 5
        wr(2'd2, 8'b000);
        rdchk(2'd2, 0, "R8 read clears before one-shot");
        wr(2'd0, 8'd5);
        wr(2'd3, 8'h01);
        #1; chk(tmr_out == 1'b0, "R6 one-shot low start", tmr_out, 0);
        idle(4); #1; chk(tmr_out == 1'b0, "R6 one-shot low end", tmr_out, 0);
        idle(1); #1; chk(tmr_out == 1'b1 && irq == 1'b0, "R6 one-shot ends, irq masked", tmr_out, 1);
        idle(4); #1; chk(tmr_out == 1'b1, "R6 stays idle", tmr_out, 1);
        wr(2'd2, 8'b001);
        #1; chk(irq == 1'b1, "R9 pending set while disabled", irq, 1);
        wr(2'd3, 8'h01);
        idle(2);
        rdchk(2'd2, 1, "R9 pending kept over restart");

        // R10 routing, one-shot over the high byte: N = 0x0104
        wr(2'd3, 8'h02);
        gp_level = 1'b0; gp_oe = 1'b0;
        wr(2'd2, 8'b101);
        #1; chk(pin0_oe == 1'b1 && pin0_out == 1'b1, "R10 routed pin high when idle", pin0_out, 1);
        wr(2'd0, 8'h04);
        wr(2'd1, 8'h01);
        wr(2'd3, 8'h01);
        #1; chk(pin0_out == 1'b0, "R10 routed pin follows timer", pin0_out, 0);
        idle(300);

        // R3 reset command
        wr(2'd2, 8'b111);
        wr(2'd3, 8'h01);
        idle(5);
        wr(2'd3, 8'h03);
        #1; chk(tmr_out == 1'b1 && irq == 1'b0 && pin0_oe == 1'b0, "R3 reset command idles", tmr_out, 1);
        rdchk(2'd0, 0, "R3 count low cleared");
        rdchk(2'd1, 0, "R3 count high cleared");
        rdchk(2'd2, 0, "R3 pending cleared");
        idle(3);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule